// File: doc/BRIEF.md
# External bus strobe generator

This block produces the two timing strobes that an embedded controller puts on its external memory bus: a high-active address latch pulse and a low-active read strobe for code memory. It runs on the oscillator clock and is told where it is in the current machine cycle by an external phase count. A machine cycle spans `MC_LEN` oscillator clocks, split into two equal halves. Each half carries one latch pulse at its start and one read-strobe slot later in the half, so the two strobes never overlap.

The surrounding core tells the block three things about the current machine cycle: whether it is an external data transfer, whether a data-move or table-read instruction is running, and whether code is being fetched from outside. During a data transfer the latch pulse of the second half and both read strobes are dropped. A single control bit, held in a small register on the core's special-register bus, can silence the latch pulse when only internal code runs. In that state the latch line is left at a weak high.

All three strobe outputs are registered. Each output shows the phase that was presented one oscillator clock earlier.

Top module: `ext_bus_strobe_gen`

## Requirements
- R1: With the latch enabled and no data transfer, `ale_o` is 1 one clock after phase value 0, 1, 6 or 7 (half-cycle offsets 0 and 1, where `mc_phase` counts 0 to 11 and values 6 to 11 form the second half). It is 0 after any other phase.
- R2: When `xdata_cyc` is 1, the latch pulse at phases 6 and 7 is dropped, so `ale_o` is 0 there. The pulse at phases 0 and 1 is kept.
- R3: When `ext_exec` is 1 and `xdata_cyc` is 0, `psen_n` is 0 one clock after phase 3, 4, 9 or 10 (half-cycle offsets 3 and 4). It is 1 after any other phase.
- R4: When `xdata_cyc` is 1, `psen_n` stays 1 for every phase.
- R5: When `ext_exec` is 0, `psen_n` stays 1 for every phase.
- R6: When the control bit is 1 and both `ext_exec` and `mv_op` are 0, `ale_o` is 1 and `ale_drive` is 0 (weak high) for every phase.
- R7: When the control bit is 1 and `mv_op` is 1, the latch behaves exactly as in R1 and R2, with `ale_drive` equal to 1.
- R8: When `ext_exec` is 1, the control bit has no effect on `ale_o` or `ale_drive`.
- R9: A write with `sfr_wr` at 1 and `sfr_addr` = 0x8E stores bit 0 of `sfr_wdata` as the control bit. Reading `sfr_rdata` at address 0x8E returns the bit in position 0 and zeros above it. Any other address reads 0, and a write to any other address leaves the bit unchanged.
- R10: A phase value of 12 or more is treated as idle: `psen_n` is 1, and the latch is not pulsed (`ale_o` is 0 when driven).
- R11: The latch pulse, when strongly driven, never coincides with `psen_n` at 0.
- R12: While `arst_n` is 0, the outputs are `ale_o`=0, `ale_drive`=1 and `psen_n`=1, and the control bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mc_phase | input | 4 | Oscillator-clock position inside the machine cycle, 0 to MC_LEN-1 |
| xdata_cyc | input | 1 | Current machine cycle is an external data transfer |
| mv_op | input | 1 | A data-move or table-read instruction is running |
| ext_exec | input | 1 | Code is being fetched from external memory |
| sfr_wr | input | 1 | Write strobe of the special-register bus |
| sfr_addr | input | 8 | Special-register address |
| sfr_wdata | input | 8 | Special-register write data |
| sfr_rdata | output | 8 | Read data, control bit in position 0 at its address |
| ale_o | output | 1 | Address latch pulse, high active |
| ale_drive | output | 1 | 1 when `ale_o` is strongly driven, 0 when the line idles weakly high |
| psen_n | output | 1 | Code-memory read strobe, low active |

## Verification
The bench sweeps every phase, including the out-of-range values, for all combinations of transfer, instruction and fetch flags, with the control bit both clear and set. A design that drops the wrong latch pulse during a data transfer would show a low at phase 0 or a high at phase 6. One that keeps any read strobe in a transfer cycle would show `psen_n` low at phase 3 or 9. The bench also checks that the control bit is overridden by external fetch and by data-move instructions; getting this wrong would leave the latch weak-high while the bus is in use. Register decode is checked with a write to a neighbouring address, and reset is applied in the middle of a run to confirm that the bit clears.

// File: rtl/bstrb_pkg.sv
package bstrb_pkg;

  // Decoded position of the current oscillator clock inside a machine cycle.
  typedef struct packed {
    logic valid;     // phase value lies inside the machine cycle
    logic upper;     // second half of the machine cycle
    logic ale_win;   // latch pulse slot of this half
    logic psen_win;  // read strobe slot of this half
  } slot_t;

  // Registered strobe state.
  typedef struct packed {
    logic ale;
    logic drive;
    logic psen_n;
  } strb_t;

endpackage

// File: rtl/bstrb_rst_sync.sv
module bstrb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= 1'b0;
        else         q <= 1'b1;
      end
      assign rst_n_o = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh <= '0;
        else         sh <= {sh[STAGES-2:0], 1'b1};
      end
      assign rst_n_o = sh[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/bstrb_ctl_reg.sv
module bstrb_ctl_reg #(
  parameter int unsigned     AW       = 8,
  parameter int unsigned     DW       = 8,
  parameter logic [AW-1:0]   REG_ADDR = 'h8E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ale_off
);

  logic hit;
  logic off_q, off_d, off_en;
  logic unused_hi;

  assign hit       = (addr == REG_ADDR);
  assign off_en    = wr & hit;
  assign unused_hi = ^wdata[DW-1:1];

  always_comb begin
    off_d = off_q;
    if (off_en) off_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= 1'b0;
    else if (off_en) off_q <= off_d;
  end

  assign rdata   = hit ? {{(DW-1){1'b0}}, off_q} : '0;
  assign ale_off = off_q;

endmodule

// File: rtl/bstrb_slot_dec.sv
module bstrb_slot_dec
  import bstrb_pkg::*;
#(
  parameter int unsigned MC_LEN   = 12,
  parameter int unsigned ALE_W    = 2,
  parameter int unsigned PS_START = 3,
  parameter int unsigned PS_W     = 2,
  parameter int unsigned PW       = $clog2(MC_LEN)
) (
  input  logic [PW-1:0] phase,
  output slot_t         slot
);

  localparam int unsigned HALF   = MC_LEN / 2;
  localparam logic [PW-1:0] HALF_P  = PW'(HALF);
  localparam logic [PW-1:0] ALE_END = PW'(ALE_W);
  localparam logic [PW-1:0] PS_LO   = PW'(PS_START);
  localparam logic [PW-1:0] PS_HI   = PW'(PS_START + PS_W);

  logic [PW-1:0] ofs;

  always_comb begin
    slot.valid = ({1'b0, phase} < (PW+1)'(MC_LEN));
    slot.upper = (phase >= HALF_P);
    ofs        = slot.upper ? (phase - HALF_P) : phase;
    slot.ale_win  = (ofs < ALE_END);
    slot.psen_win = (ofs >= PS_LO) && (ofs < PS_HI);
  end

endmodule

// File: rtl/bstrb_out.sv
module bstrb_out
  import bstrb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  slot_t slot,
  input  logic  xdata_cyc,
  input  logic  mv_op,
  input  logic  ext_exec,
  input  logic  ale_off,
  output strb_t strb
);

  strb_t nxt, cur;
  logic  ale_allowed, ale_pulse, psen_pulse;

  always_comb begin
    ale_allowed = ~ale_off | ext_exec | mv_op;
    ale_pulse   = slot.valid & slot.ale_win & ~(xdata_cyc & slot.upper);
    psen_pulse  = slot.valid & slot.psen_win & ext_exec & ~xdata_cyc;
    nxt.ale     = ale_allowed ? ale_pulse : 1'b1;
    nxt.drive   = ale_allowed;
    nxt.psen_n  = ~psen_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur.ale    <= 1'b0;
      cur.drive  <= 1'b1;
      cur.psen_n <= 1'b1;
    end else begin
      cur <= nxt;
    end
  end

  assign strb = cur;

endmodule

// File: rtl/ext_bus_strobe_gen.sv
module ext_bus_strobe_gen
  import bstrb_pkg::*;
#(
  parameter int unsigned   MC_LEN    = 12,
  parameter int unsigned   ALE_W     = 2,
  parameter int unsigned   PS_START  = 3,
  parameter int unsigned   PS_W      = 2,
  parameter int unsigned   SYNC_STG  = 2,
  parameter int unsigned   AW        = 8,
  parameter int unsigned   DW        = 8,
  parameter logic [AW-1:0] CTL_ADDR  = 'h8E,
  localparam int unsigned  PW        = $clog2(MC_LEN)
) (
  input  logic          osc_clk,
  input  logic          arst_n,
  input  logic [PW-1:0] mc_phase,
  input  logic          xdata_cyc,
  input  logic          mv_op,
  input  logic          ext_exec,
  input  logic          sfr_wr,
  input  logic [AW-1:0] sfr_addr,
  input  logic [DW-1:0] sfr_wdata,
  output logic [DW-1:0] sfr_rdata,
  output logic          ale_o,
  output logic          ale_drive,
  output logic          psen_n
);

  logic  rst_core_n;
  logic  ale_off;
  slot_t slot;
  strb_t strb;

  bstrb_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk     (osc_clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_core_n)
  );

  bstrb_ctl_reg #(.AW(AW), .DW(DW), .REG_ADDR(CTL_ADDR)) u_reg (
    .clk     (osc_clk),
    .rst_n   (rst_core_n),
    .wr      (sfr_wr),
    .addr    (sfr_addr),
    .wdata   (sfr_wdata),
    .rdata   (sfr_rdata),
    .ale_off (ale_off)
  );

  bstrb_slot_dec #(
    .MC_LEN(MC_LEN), .ALE_W(ALE_W), .PS_START(PS_START), .PS_W(PS_W), .PW(PW)
  ) u_dec (
    .phase (mc_phase),
    .slot  (slot)
  );

  bstrb_out u_out (
    .clk       (osc_clk),
    .rst_n     (rst_core_n),
    .slot      (slot),
    .xdata_cyc (xdata_cyc),
    .mv_op     (mv_op),
    .ext_exec  (ext_exec),
    .ale_off   (ale_off),
    .strb      (strb)
  );

  assign ale_o     = strb.ale;
  assign ale_drive = strb.drive;
  assign psen_n    = strb.psen_n;

endmodule

// File: rtl/ext_bus_strobe_gen_chk.sv
module ext_bus_strobe_gen_chk #(
  parameter int unsigned   MC_LEN   = 12,
  parameter int unsigned   PW       = 4,
  parameter int unsigned   AW       = 8,
  parameter logic [AW-1:0] CTL_ADDR = 'h8E
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] mc_phase,
  input logic          xdata_cyc,
  input logic          mv_op,
  input logic          ext_exec,
  input logic          sfr_wr,
  input logic [AW-1:0] sfr_addr,
  input logic          ale_off,
  input logic          ale_o,
  input logic          ale_drive,
  input logic          psen_n
);

  localparam logic [PW-1:0] HALF_P = PW'(MC_LEN / 2);

  logic v_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= 1'b1;
  end

  // R11
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale_o && ale_drive && !psen_n));

  // R5
  a_r5_psen_idle_internal: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !$past(ext_exec)) |-> psen_n);

  // R4
  a_r4_xdata_no_psen: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && $past(xdata_cyc)) |-> psen_n);

  // R2
  a_r2_drop_upper_ale: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && $past(xdata_cyc && (mc_phase == HALF_P))) |-> !(ale_o && ale_drive));

  // R6
  a_r6_weak_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && $past(ale_off && !ext_exec && !mv_op)) |-> (ale_o && !ale_drive));

  // R8
  a_r8_ext_overrides: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && $past(ext_exec)) |-> ale_drive);

  // R10
  a_r10_bad_phase_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && $past({1'b0, mc_phase} >= (PW+1)'(MC_LEN))) |-> (psen_n && !(ale_o && ale_drive)));

  // R9
  a_r9_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !$past(sfr_wr && (sfr_addr == CTL_ADDR))) |-> $stable(ale_off));

endmodule

bind ext_bus_strobe_gen ext_bus_strobe_gen_chk #(
  .MC_LEN(MC_LEN), .PW(PW), .AW(AW), .CTL_ADDR(CTL_ADDR)
) u_chk (
  .clk       (osc_clk),
  .rst_n     (rst_core_n),
  .mc_phase  (mc_phase),
  .xdata_cyc (xdata_cyc),
  .mv_op     (mv_op),
  .ext_exec  (ext_exec),
  .sfr_wr    (sfr_wr),
  .sfr_addr  (sfr_addr),
  .ale_off   (ale_off),
  .ale_o     (ale_o),
  .ale_drive (ale_drive),
  .psen_n    (psen_n)
);

// File: tb/ext_bus_strobe_gen_test.sv
module ext_bus_strobe_gen_test;

  logic       osc_clk = 1'b0;
  logic       arst_n;
  logic [3:0] mc_phase;
  logic       xdata_cyc, mv_op, ext_exec, sfr_wr;
  logic [7:0] sfr_addr, sfr_wdata, sfr_rdata;
  logic       ale_o, ale_drive, psen_n;

  int n_chk = 0;
  int n_bad = 0;

  always #10 osc_clk = ~osc_clk;

  ext_bus_strobe_gen uut (
    .osc_clk   (osc_clk),
    .arst_n    (arst_n),
    .mc_phase  (mc_phase),
    .xdata_cyc (xdata_cyc),
    .mv_op     (mv_op),
    .ext_exec  (ext_exec),
    .sfr_wr    (sfr_wr),
    .sfr_addr  (sfr_addr),
    .sfr_wdata (sfr_wdata),
    .sfr_rdata (sfr_rdata),
    .ale_o     (ale_o),
    .ale_drive (ale_drive),
    .psen_n    (psen_n)
  );

  // {phase[3:0], ext, xdata, mv, exp_ale, exp_drive, exp_psen_n}; control bit clear
  localparam logic [9:0] VEC [18] = '{
    {4'd0,  3'b000, 3'b111}, {4'd1,  3'b000, 3'b111}, {4'd2,  3'b000, 3'b011},
    {4'd6,  3'b000, 3'b111}, {4'd7,  3'b000, 3'b111}, {4'd8,  3'b000, 3'b011},
    {4'd3,  3'b100, 3'b010}, {4'd4,  3'b100, 3'b010}, {4'd5,  3'b100, 3'b011},
    {4'd9,  3'b100, 3'b010}, {4'd10, 3'b100, 3'b010}, {4'd11, 3'b100, 3'b011},
    {4'd0,  3'b110, 3'b111}, {4'd6,  3'b110, 3'b011}, {4'd3,  3'b110, 3'b011},
    {4'd9,  3'b010, 3'b011}, {4'd7,  3'b010, 3'b011}, {4'd1,  3'b010, 3'b111}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected strobes from the requirements: {ale, drive, psen_n}
  function automatic logic [2:0] model(int ph, bit ext, bit xd, bit mv, bit off);
    bit valid, upper, allowed, pulse, ps;
    int ofs;
    valid   = (ph < 12);
    upper   = (ph >= 6);
    ofs     = upper ? ph - 6 : ph;
    allowed = !off || ext || mv;
    pulse   = valid && (ofs < 2) && !(xd && upper);
    ps      = valid && (ofs == 3 || ofs == 4) && ext && !xd;
    return {allowed ? pulse : 1'b1, allowed, !ps};
  endfunction

  task automatic apply(input int ph, input bit ext, input bit xd, input bit mv);
    @(negedge osc_clk);
    mc_phase  = 4'(ph);
    ext_exec  = ext;
    xdata_cyc = xd;
    mv_op     = mv;
    @(posedge osc_clk);
    #2;
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge osc_clk);
    sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(posedge osc_clk);
    #2;
    sfr_wr = 1'b0;
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge osc_clk);
    sfr_addr = a;
    #1;
    d = sfr_rdata;
  endtask

  task automatic sweep(input bit off, input string tag);
    for (int c = 0; c < 8; c++) begin
      for (int ph = 0; ph < 16; ph++) begin
        apply(ph, c[2], c[1], c[0]);
        check(tag, {5'd0, ale_o, ale_drive, psen_n}, {5'd0, model(ph, c[2], c[1], c[0], off)});
        check("R11 no overlap", {7'd0, ale_o & ale_drive & ~psen_n}, 8'd0);
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    arst_n = 1'b0; mc_phase = '0; xdata_cyc = 0; mv_op = 0; ext_exec = 0;
    sfr_wr = 0; sfr_addr = 8'h8E; sfr_wdata = '0;
    repeat (3) @(posedge osc_clk);
    #2;
    check("R12 reset outputs", {5'd0, ale_o, ale_drive, psen_n}, 8'b011);
    check("R12 reset bit", sfr_rdata, 8'h00);
    @(negedge osc_clk) arst_n = 1'b1;
    repeat (4) @(posedge osc_clk);

    // Table of vectors: R1, R2, R3, R4
    for (int i = 0; i < 18; i++) begin
      apply(int'(VEC[i][9:6]), VEC[i][5], VEC[i][4], VEC[i][3]);
      check("R1/R2/R3/R4 table", {5'd0, ale_o, ale_drive, psen_n}, {5'd0, VEC[i][2:0]});
    end

    // Full sweep with control bit clear: R1 R2 R3 R4 R5 R10
    sweep(1'b0, "R1/R2/R3/R4/R5/R10 sweep");

    // Register: R9
    sfr_write(8'h8E, 8'hFF);
    sfr_read(8'h8E, rd);
    check("R9 readback set", rd, 8'h01);
    sfr_read(8'h8F, rd);
    check("R9 other address reads zero", rd, 8'h00);
    sfr_write(8'h8F, 8'h00);
    sfr_read(8'h8E, rd);
    check("R9 foreign write ignored", rd, 8'h01);

    // Weak idle and overrides: R6 R7 R8 R10
    apply(0, 0, 0, 0);
    check("R6 weak high", {6'd0, ale_o, ale_drive}, 8'b10);
    apply(0, 0, 0, 1);
    check("R7 data-move overrides", {6'd0, ale_o, ale_drive}, 8'b11);
    apply(6, 1, 0, 0);
    check("R8 external fetch overrides", {6'd0, ale_o, ale_drive}, 8'b11);
    sweep(1'b1, "R6/R7/R8/R10 sweep");

    sfr_write(8'h8E, 8'h00);
    sfr_read(8'h8E, rd);
    check("R9 readback clear", rd, 8'h00);
    sfr_write(8'h8E, 8'h01);

    // Reset mid-run: R12 and R9
    @(negedge osc_clk) arst_n = 1'b0;
    #2;
    check("R12 mid-run reset outputs", {5'd0, ale_o, ale_drive, psen_n}, 8'b011);
    check("R9 reset clears bit", sfr_rdata, 8'h00);
    @(negedge osc_clk) arst_n = 1'b1;
    repeat (4) @(posedge osc_clk);
    apply(1, 0, 0, 0);
    check("R1 after reset", {5'd0, ale_o, ale_drive, psen_n}, 8'b111);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule